// File: doc/BRIEF.md
# SDRAM Initialization and Refresh Scheduler

This block is the control core of an external-bus SDRAM port. Once software turns on the SDRAM chip-select slot, the core brings the memory up by itself. It waits a programmable power-up delay, precharges all banks, issues two auto-refresh commands, each followed by a programmable recovery wait, and finally loads the mode register from the value already on its `mode_value` input. Nothing else can use the memory while this runs. Access requests are held off and a software mode-load request is ignored.

After initialization the core keeps the memory alive on its own. A counter measured against a programmable period produces refresh demands. Each demand goes into a small pending bank, which holds up to four of them. This bank absorbs demands that arrive while the bus is serving an access. The idle state arbitrates the pending refreshes against ordinary access requests from the external bus arbiter and against an explicit software mode-register load. Refresh has the highest priority and software mode-load the lowest. The address and data paths are handled elsewhere. The core drives only the SDRAM command pins, clock enable, the mode bits during a mode load, and the busy, ready and overflow flags.

Top module: `sdram_ctl_core`

## Requirements
- R1: During and after reset, until `cfg_sdram_en` is seen high, `cmd_cke` is 0 and the command pins show deselect ({cs_n,ras_n,cas_n,we_n} = 4'b1111). In this state `busy`, `ready`, `acc_grant` and `ref_ovf` are all 0.
- R2: The first cycle with `cfg_sdram_en` high starts initialization. From the next cycle on, `cmd_cke` is 1 and `busy` is 1, and NOP (4'b0111) is driven for max(`pwrup_wait`,1) cycles.
- R3: The power-up wait is followed by these steps in order, each command lasting one cycle:
  - PRECHARGE ALL (4'b0010);
  - AUTO REFRESH (4'b0001), then max(`trfc_wait`,1) NOP cycles;
  - a second AUTO REFRESH, then max(`trfc_wait`,1) NOP cycles;
  - LOAD MODE (4'b0000), with `mode_bus` equal to `mode_value` in that cycle.
  In the following cycle `ready` rises and stays high, and `busy` is 0.
- R4: While `ready` is 0, `acc_grant` stays 0 whatever `acc_req` does. A `lmr_req` that is high only while `ready` is 0 never produces a LOAD MODE command afterwards.
- R5: After `ready`, with a nonzero `refresh_period` of N, the first AUTO REFRESH appears N+1 cycles after the first ready cycle. Later ones follow every N cycles while the bus is otherwise idle. Each refresh is followed by max(`trfc_wait`,1) NOP cycles. A period of 0 issues no refresh.
- R6: In the idle state, with no refresh pending, a high `acc_req` gives `acc_grant` = 1 from the next cycle. The grant holds, with NOP on the command pins, until `acc_done` is sampled high. It drops in the following cycle.
- R7: Refreshes that fall due during an access are banked, up to four. None is issued while the grant is held. After the grant ends they are issued back to back, each with its recovery wait.
- R8: A refresh that falls due while four are already banked, and none is being issued, is dropped and sets `ref_ovf`. `ref_ovf` then stays 1 until reset.
- R9: If a refresh is pending in the same idle cycle that `acc_req` is high, the refresh command is issued first. The grant follows only after the refresh recovery wait.
- R10: A `lmr_req` pulse accepted while `ready` is 1 produces one LOAD MODE command, with `mode_bus` equal to `mode_value`, in the first idle cycle that has no pending refresh and no access request. With an idle bus this is two cycles after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sdram_en | input | 1 | Chip-select slot configured as SDRAM; starts initialization |
| refresh_period | input | PERIOD_W | Cycles between refresh demands; 0 disables |
| pwrup_wait | input | WAIT_W | Power-up NOP cycles (0 acts as 1) |
| trfc_wait | input | WAIT_W | Recovery NOP cycles after each refresh (0 acts as 1) |
| mode_value | input | MODE_W | Mode register contents driven during a mode load |
| acc_req | input | 1 | Access request from the bus arbiter |
| acc_done | input | 1 | Granted access has finished |
| lmr_req | input | 1 | Software mode-load request pulse |
| acc_grant | output | 1 | Access granted; command pins hold NOP |
| cmd_cs_n | output | 1 | SDRAM chip select, active low |
| cmd_ras_n | output | 1 | SDRAM row strobe, active low |
| cmd_cas_n | output | 1 | SDRAM column strobe, active low |
| cmd_we_n | output | 1 | SDRAM write enable, active low |
| cmd_cke | output | 1 | SDRAM clock enable |
| mode_bus | output | MODE_W | Mode bits during a mode load, 0 otherwise |
| busy | output | 1 | Initialization, refresh, mode load or access in progress |
| ready | output | 1 | Initialization complete |
| ref_ovf | output | 1 | Sticky: a refresh demand was dropped |

## Verification
The bench sweeps every pairing of power-up and recovery waits from 0 to 3 and compares the whole initialization trace cycle by cycle. A design that mishandled a zero wait would wrap its counter and stall, and one that dropped a wait cycle would shift every later command. Refresh timing is measured against the counter phase computed from the first ready cycle, with accesses held across two, four and five refresh periods. A design without saturation would issue five refreshes, and one that never dropped a demand would leave the overflow flag low. The bench also presents an access request in the exact cycle a refresh becomes pending, so a design that gave the bus to accesses first shows a grant before the refresh command. Mode-load requests are placed both during initialization, where they must be ignored, and behind a held access, where they must wait for the access to finish.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_PWRUP,
        ST_PRE,
        ST_RF1,
        ST_W1,
        ST_RF2,
        ST_W2,
        ST_LMR,
        ST_IDLE,
        ST_ACC,
        ST_REF,
        ST_RWAIT,
        ST_ULMR
    } sdr_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_DESEL = 4'b1111;
    localparam sdr_cmd_t CMD_NOP   = 4'b0111;
    localparam sdr_cmd_t CMD_PREA  = 4'b0010;
    localparam sdr_cmd_t CMD_AREF  = 4'b0001;
    localparam sdr_cmd_t CMD_LMR   = 4'b0000;

endpackage

// File: rtl/sdr_refresh_bank.sv
module sdr_refresh_bank #(
    parameter int PERIOD_W = 16,
    parameter int MAX_PEND = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [PERIOD_W-1:0] period,
    input  logic                take,
    output logic                pend_nz,
    output logic                ovf
);
    localparam int CTW = $clog2(MAX_PEND + 1);
    localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);
    localparam logic [CTW-1:0] FULL = CTW'(MAX_PEND);

    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
        logic [CTW-1:0]      pend;
        logic                ovf;
    } bank_s;

    bank_s q, d;
    logic  active;
    logic  tick;

    always_comb begin
        d      = q;
        active = run && (period != '0);
        tick   = active && (q.cnt >= period - ONE);
        if (!active) begin
            d.cnt = '0;
        end else if (tick) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + ONE;
        end
        // take is only raised by the sequencer when pend is nonzero
        if (tick && !take) begin
            if (q.pend == FULL) begin
                d.ovf = 1'b1;
            end else begin
                d.pend = q.pend + CTW'(1);
            end
        end else if (!tick && take) begin
            d.pend = q.pend - CTW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pend_nz = (q.pend != '0);
    assign ovf     = q.ovf;

endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
    import sdr_pkg::*;
#(
    parameter int WAIT_W = 8,
    parameter int MODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [WAIT_W-1:0] pwrup_wait,
    input  logic [WAIT_W-1:0] trfc_wait,
    input  logic [MODE_W-1:0] mode_value,
    input  logic              acc_req,
    input  logic              acc_done,
    input  logic              lmr_req,
    input  logic              ref_pend,
    output logic              ref_take,
    output logic              done,
    output sdr_cmd_t          cmd,
    output logic              cke,
    output logic [MODE_W-1:0] mode_bus,
    output logic              grant,
    output logic              busy
);
    localparam logic [WAIT_W-1:0] W_ONE = WAIT_W'(1);

    typedef struct packed {
        sdr_state_e        st;
        logic [WAIT_W-1:0] cnt;
        logic              done;
        logic              lmr_pend;
    } seq_s;

    seq_s q, d;

    function automatic logic [WAIT_W-1:0] at_least_one(input logic [WAIT_W-1:0] v);
        return (v == '0) ? W_ONE : v;
    endfunction

    always_comb begin
        d        = q;
        ref_take = 1'b0;
        case (q.st)
            ST_OFF: begin
                if (cfg_en) begin
                    d.st  = ST_PWRUP;
                    d.cnt = at_least_one(pwrup_wait);
                end
            end
            ST_PWRUP: begin
                if (q.cnt <= W_ONE) d.st = ST_PRE;
                else                d.cnt = q.cnt - W_ONE;
            end
            ST_PRE: d.st = ST_RF1;
            ST_RF1: begin
                d.st  = ST_W1;
                d.cnt = at_least_one(trfc_wait);
            end
            ST_W1: begin
                if (q.cnt <= W_ONE) d.st = ST_RF2;
                else                d.cnt = q.cnt - W_ONE;
            end
            ST_RF2: begin
                d.st  = ST_W2;
                d.cnt = at_least_one(trfc_wait);
            end
            ST_W2: begin
                if (q.cnt <= W_ONE) d.st = ST_LMR;
                else                d.cnt = q.cnt - W_ONE;
            end
            ST_LMR: begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end
            ST_IDLE: begin
                if (ref_pend) begin
                    ref_take = 1'b1;
                    d.st     = ST_REF;
                end else if (acc_req) begin
                    d.st = ST_ACC;
                end else if (q.lmr_pend) begin
                    d.st = ST_ULMR;
                end
            end
            ST_ACC: begin
                if (acc_done) d.st = ST_IDLE;
            end
            ST_REF: begin
                d.st  = ST_RWAIT;
                d.cnt = at_least_one(trfc_wait);
            end
            ST_RWAIT: begin
                if (q.cnt <= W_ONE) d.st = ST_IDLE;
                else                d.cnt = q.cnt - W_ONE;
            end
            ST_ULMR: begin
                d.st       = ST_IDLE;
                d.lmr_pend = 1'b0;
            end
            default: d.st = ST_OFF;
        endcase
        if (lmr_req && q.done) d.lmr_pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_OFF, cnt: '0, done: 1'b0, lmr_pend: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.st)
            ST_OFF:                 cmd = CMD_DESEL;
            ST_PRE:                 cmd = CMD_PREA;
            ST_RF1, ST_RF2, ST_REF: cmd = CMD_AREF;
            ST_LMR, ST_ULMR:        cmd = CMD_LMR;
            default:                cmd = CMD_NOP;
        endcase
        mode_bus = (q.st == ST_LMR || q.st == ST_ULMR) ? mode_value : '0;
    end

    assign cke   = (q.st != ST_OFF);
    assign grant = (q.st == ST_ACC);
    assign busy  = (q.st != ST_OFF) && (q.st != ST_IDLE);
    assign done  = q.done;

endmodule

// File: rtl/sdram_ctl_core.sv
module sdram_ctl_core
    import sdr_pkg::*;
#(
    parameter int PERIOD_W = 16,
    parameter int WAIT_W   = 8,
    parameter int MODE_W   = 12,
    parameter int MAX_PEND = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_sdram_en,
    input  logic [PERIOD_W-1:0] refresh_period,
    input  logic [WAIT_W-1:0]   pwrup_wait,
    input  logic [WAIT_W-1:0]   trfc_wait,
    input  logic [MODE_W-1:0]   mode_value,
    input  logic                acc_req,
    input  logic                acc_done,
    input  logic                lmr_req,
    output logic                acc_grant,
    output logic                cmd_cs_n,
    output logic                cmd_ras_n,
    output logic                cmd_cas_n,
    output logic                cmd_we_n,
    output logic                cmd_cke,
    output logic [MODE_W-1:0]   mode_bus,
    output logic                busy,
    output logic                ready,
    output logic                ref_ovf
);
    logic     pend_nz;
    logic     ref_take;
    logic     init_done;
    sdr_cmd_t cmd;

    sdr_refresh_bank #(
        .PERIOD_W (PERIOD_W),
        .MAX_PEND (MAX_PEND)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (init_done),
        .period  (refresh_period),
        .take    (ref_take),
        .pend_nz (pend_nz),
        .ovf     (ref_ovf)
    );

    sdr_cmd_seq #(
        .WAIT_W (WAIT_W),
        .MODE_W (MODE_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_sdram_en),
        .pwrup_wait (pwrup_wait),
        .trfc_wait  (trfc_wait),
        .mode_value (mode_value),
        .acc_req    (acc_req),
        .acc_done   (acc_done),
        .lmr_req    (lmr_req),
        .ref_pend   (pend_nz),
        .ref_take   (ref_take),
        .done       (init_done),
        .cmd        (cmd),
        .cke        (cmd_cke),
        .mode_bus   (mode_bus),
        .grant      (acc_grant),
        .busy       (busy)
    );

    assign cmd_cs_n  = cmd.cs_n;
    assign cmd_ras_n = cmd.ras_n;
    assign cmd_cas_n = cmd.cas_n;
    assign cmd_we_n  = cmd.we_n;
    assign ready     = init_done;

endmodule

// File: rtl/sdram_ctl_core_chk.sv
module sdram_ctl_core_chk
    import sdr_pkg::*;
#(
    parameter int MODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_cs_n,
    input logic              cmd_ras_n,
    input logic              cmd_cas_n,
    input logic              cmd_we_n,
    input logic              cmd_cke,
    input logic              acc_grant,
    input logic              busy,
    input logic              ready,
    input logic              ref_ovf,
    input logic [MODE_W-1:0] mode_bus,
    input logic [MODE_W-1:0] mode_value
);
    logic [3:0] pins;
    assign pins = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};

    p_off_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_cke |-> (cmd_cs_n && !busy && !acc_grant && !ready));

    p_no_grant_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !acc_grant);

    p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    p_mode_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == CMD_LMR) |-> (mode_bus == mode_value));

    p_refresh_recovers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == CMD_AREF) |=> (pins == CMD_NOP));

    p_grant_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |-> (pins == CMD_NOP && busy));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ovf |=> ref_ovf);

endmodule

bind sdram_ctl_core sdram_ctl_core_chk #(.MODE_W(MODE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_cs_n   (cmd_cs_n),
    .cmd_ras_n  (cmd_ras_n),
    .cmd_cas_n  (cmd_cas_n),
    .cmd_we_n   (cmd_we_n),
    .cmd_cke    (cmd_cke),
    .acc_grant  (acc_grant),
    .busy       (busy),
    .ready      (ready),
    .ref_ovf    (ref_ovf),
    .mode_bus   (mode_bus),
    .mode_value (mode_value)
);

// File: tb/sdram_ctl_core_tb_top.sv
`timescale 1ns/1ps
module sdram_ctl_core_tb_top;
    localparam int PW = 8;
    localparam int WW = 4;
    localparam int MW = 12;

    localparam logic [3:0] C_DES  = 4'b1111;
    localparam logic [3:0] C_NOP  = 4'b0111;
    localparam logic [3:0] C_PRE  = 4'b0010;
    localparam logic [3:0] C_AREF = 4'b0001;
    localparam logic [3:0] C_LMR  = 4'b0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic [PW-1:0] per = '0;
    logic [WW-1:0] pw = '0;
    logic [WW-1:0] tw = '0;
    logic [MW-1:0] mval = '0;
    logic          acc_req = 1'b0;
    logic          acc_done = 1'b0;
    logic          lmr_req = 1'b0;
    logic          grant, cs_n, ras_n, cas_n, we_n, cke, busy, ready, ovf;
    logic [MW-1:0] mbus;
    wire  [3:0]    pins = {cs_n, ras_n, cas_n, we_n};

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int r0 = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sdram_ctl_core #(.PERIOD_W(PW), .WAIT_W(WW), .MODE_W(MW), .MAX_PEND(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_sdram_en(cfg_en), .refresh_period(per),
        .pwrup_wait(pw), .trfc_wait(tw), .mode_value(mval), .acc_req(acc_req),
        .acc_done(acc_done), .lmr_req(lmr_req), .acc_grant(grant),
        .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
        .cmd_cke(cke), .mode_bus(mbus), .busy(busy), .ready(ready), .ref_ovf(ovf)
    );

    task automatic step();
        @(negedge clk);
        cyc++;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_en = 1'b0; acc_req = 1'b0; acc_done = 1'b0; lmr_req = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    function automatic logic [3:0] exp_init(input int i, input int ep, input int et);
        if (i < ep)               return C_NOP;
        if (i == ep)              return C_PRE;
        if (i == ep + 1)          return C_AREF;
        if (i < ep + 2 + et)      return C_NOP;
        if (i == ep + 2 + et)     return C_AREF;
        if (i < ep + 3 + 2 * et)  return C_NOP;
        return C_LMR;
    endfunction

    task automatic run_init(input int p, input int t, input bit hold);
        int ep = (p == 0) ? 1 : p;
        int et = (t == 0) ? 1 : t;
        int last = ep + 3 + 2 * et;
        logic [3:0] e;
        pw = WW'(p); tw = WW'(t);
        mval = MW'(12'h100 + p * 16 + t);
        cfg_en = 1'b1;
        if (hold) begin acc_req = 1'b1; lmr_req = 1'b1; end
        for (int i = 0; i <= last; i++) begin
            step();
            e = exp_init(i, ep, et);
            if (i < ep) check(pins == e && cke && busy && !ready, "R2", {cke, busy, ready, pins}, {3'b110, e});
            else        check(pins == e && cke && busy && !ready, "R3", {cke, busy, ready, pins}, {3'b110, e});
            if (i == last) check(mbus == mval, "R3 mode", int'(mbus), int'(mval));
            if (hold) check(!grant, "R4 grant", int'(grant), 0);
        end
        lmr_req = 1'b0;
        step();
        r0 = cyc;
        check(ready && !busy && pins == C_NOP, "R3 ready", {ready, busy, pins}, {2'b10, C_NOP});
    endtask

    task automatic bank_test(input int n);
        int refs = 0;
        int exp_refs = (n > 4) ? 4 : n;
        do_reset();
        per = 8'd30;
        run_init(1, 2, 1'b0);
        while (cyc < r0 + 6) step();
        acc_req = 1'b1;
        step();
        check(grant == 1'b1, "R6 grant", int'(grant), 1);
        while (cyc < r0 + 6 + 30 * n) begin
            step();
            if (pins == C_AREF) refs++;
        end
        check(refs == 0 && grant, "R7 hold", refs, 0);
        acc_done = 1'b1; acc_req = 1'b0;
        for (int k = 0; k < 16; k++) begin
            step();
            acc_done = 1'b0;
            if (k == 0) check(!grant, "R6 release", int'(grant), 0);
            if (pins == C_AREF) refs++;
        end
        check(refs == exp_refs, "R7 burst", refs, exp_refs);
        check(ovf == (n > 4), "R8 ovf", int'(ovf), int'(n > 4));
        repeat (5) step();
        check(ovf == (n > 4), "R8 sticky", int'(ovf), int'(n > 4));
    endtask

    initial begin
        repeat (2) step();
        check(!cke && cs_n && !busy && !ready && !grant && !ovf, "R1 in reset",
              {cke, cs_n, busy, ready, grant}, 5'b01000);
        do_reset();
        repeat (3) begin
            step();
            check(!cke && pins == C_DES && !busy && !ready && !grant && !ovf, "R1 idle",
                  {cke, busy, ready, pins}, {3'b000, C_DES});
        end

        // R2 / R3: sweep of power-up and recovery waits
        per = '0;
        for (int p = 0; p < 4; p++) begin
            for (int t = 0; t < 4; t++) begin
                do_reset();
                run_init(p, t, 1'b0);
            end
        end

        // R4: requests during initialization
        do_reset();
        run_init(2, 1, 1'b1);
        step();
        check(grant == 1'b1, "R6 grant after ready", int'(grant), 1);
        repeat (3) begin
            step();
            check(grant && pins == C_NOP, "R6 hold", {grant, pins}, {1'b1, C_NOP});
        end
        acc_done = 1'b1; acc_req = 1'b0;
        step();
        acc_done = 1'b0;
        check(!grant, "R6 drop", int'(grant), 0);
        for (int k = 0; k < 6; k++) begin
            step();
            check(pins != C_LMR, "R4 early lmr ignored", int'(pins), int'(C_NOP));
        end

        // R5: refresh cadence for several periods
        for (int s = 0; s < 3; s++) begin
            int pv = (s == 0) ? 5 : ((s == 1) ? 8 : 13);
            int seen = 0;
            int last_ref = 0;
            do_reset();
            per = PW'(pv);
            run_init(1, 2, 1'b0);
            for (int k = 0; k < 60 && seen < 3; k++) begin
                step();
                if (pins == C_AREF) begin
                    if (seen == 0) check(cyc == r0 + pv + 1, "R5 first", cyc - r0, pv + 1);
                    else           check(cyc - last_ref == pv, "R5 gap", cyc - last_ref, pv);
                    last_ref = cyc;
                    seen++;
                    step();
                    check(pins == C_NOP, "R5 recovery", int'(pins), int'(C_NOP));
                end
            end
            check(seen == 3, "R5 count", seen, 3);
        end

        // R7 / R8: banking and saturation
        bank_test(2);
        bank_test(4);
        bank_test(5);

        // R9: refresh pending and access request in the same cycle
        do_reset();
        per = 8'd30;
        run_init(1, 2, 1'b0);
        while (cyc < r0 + 30) step();
        acc_req = 1'b1;
        step();
        check(pins == C_AREF && !grant, "R9 refresh first", {grant, pins}, {1'b0, C_AREF});
        repeat (3) begin
            step();
            check(!grant, "R9 grant waits", int'(grant), 0);
        end
        step();
        check(grant, "R9 grant after", int'(grant), 1);
        acc_done = 1'b1; acc_req = 1'b0;
        step();
        acc_done = 1'b0;

        // R10: software mode load, and R5 with period 0
        do_reset();
        per = '0;
        run_init(1, 1, 1'b0);
        repeat (2) step();
        mval = 12'h5A3;
        lmr_req = 1'b1;
        step();
        lmr_req = 1'b0;
        check(pins == C_NOP, "R10 wait slot", int'(pins), int'(C_NOP));
        step();
        check(pins == C_LMR && mbus == 12'h5A3, "R10 load", int'(mbus), 12'h5A3);
        step();
        check(pins == C_NOP && ready && mbus == '0, "R10 after", int'(pins), int'(C_NOP));
        mval = 12'h3C6;
        acc_req = 1'b1; lmr_req = 1'b1;
        step();
        lmr_req = 1'b0;
        check(grant, "R10 access first", int'(grant), 1);
        repeat (3) begin
            step();
            check(pins != C_LMR && grant, "R10 deferred", int'(pins), int'(C_NOP));
        end
        acc_done = 1'b1; acc_req = 1'b0;
        step();
        acc_done = 1'b0;
        check(pins == C_NOP && !grant, "R10 idle slot", int'(pins), int'(C_NOP));
        step();
        check(pins == C_LMR && mbus == 12'h3C6, "R10 deferred load", int'(mbus), 12'h3C6);
        begin
            int refs = 0;
            for (int k = 0; k < 60; k++) begin
                step();
                if (pins == C_AREF) refs++;
            end
            check(refs == 0, "R5 period zero", refs, 0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog (all requirements): actual hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule